// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer

An 8-bit counter that paces itself on a clock-enable tick and runs in one of four counting modes: free-running, wrap at a terminal value, one-shot countdown, and triangle up/down. A compare input gives the terminal value. A sticky overflow flag records each terminal event. A pending interrupt flag and an interrupt request sit on top of that flag and are gated by a per-timer mask and a global enable.

The counter moves only on cycles where both the tick and the run control are high. When run is low, or the mode select changes, the counter goes back to the start value of the selected mode: the terminal value in countdown mode and zero in every other mode. A clear strobe resets the overflow and pending flags. Mode encoding on `mode_i`: 0 = free-running, 1 = modulo, 2 = countdown, 3 = up/down.

Top module: `mode_timer8`

## Requirements
- R1: In free-running mode (0) the count goes 0x00 to 0xFF and wraps to 0x00. The overflow flag sets on the tick that wraps from 0xFF.
- R2: In modulo mode (1) a tick with the count at or above the terminal value reloads 0x00 and sets the overflow flag. Any other tick increments the count.
- R3: In countdown mode (2) the counter holds the terminal value while idle. Each tick then decrements it, and it stays at 0x00 once there. The flag sets only on the tick that takes the count from 0x01 to 0x00, so a terminal value of 0 never sets it.
- R4: In up/down mode (3) the count rises from 0x00 to the terminal value and falls back to 0x00, then rises again. The flag sets each time the count reaches 0x00 and never at the upper turn.
- R5: The count changes only on a cycle with both tick and run high. While run is low the count shows the start value of the selected mode.
- R6: A change of mode select loads the start value of the new mode, even while running. No count step is taken on that cycle.
- R7: The overflow flag stays set until a clear strobe. When a set event and a clear strobe fall in the same cycle, the flag ends up set.
- R8: The pending flag sets only on an overflow event that happens while the mask is 1. It clears with the overflow flag, and it never sets while the overflow flag is low.
- R9: The interrupt request is high exactly when the pending flag, the mask and the global enable are all 1.
- R10: A terminal value of 0 in modulo or up/down mode keeps the count at 0x00 and sets the flag on every tick.
- R11: Reset gives a count of 0x00 and clears both flags and the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable tick that advances the counter |
| run_i | input | 1 | Run control; low holds the mode start value |
| mode_i | input | 2 | Counting mode select (0 free, 1 modulo, 2 countdown, 3 up/down) |
| term_i | input | 8 | Terminal count value |
| ovf_mask_i | input | 1 | Overflow interrupt mask |
| irq_en_i | input | 1 | Global timer interrupt enable |
| clr_i | input | 1 | Clear strobe for the overflow and pending flags |
| count_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| pend_o | output | 1 | Pending interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level rules on every cycle:
- the count stays still on idle ticks;
- the flag is sticky without a clear;
- pending implies the flag is set;
- the modulo wrap lands on zero with the flag set;
- the countdown holds at zero;
- the upper turn of the triangle raises no flag.

Only the bench's scenarios can show the full sequences: the exact count at each step in each mode, the set-beats-clear order, and the masked event that leaves pending low. They also cover the mode-change reload and the zero-terminal corner cases.

// File: rtl/mode_timer8.sv
module mode_timer8 #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] term_i,
  input  logic         ovf_mask_i,
  input  logic         irq_en_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o,
  output logic         ovf_flag_o,
  output logic         pend_o,
  output logic         irq_o
);

  localparam logic [1:0]   M_FREE = 2'd0;
  localparam logic [1:0]   M_MOD  = 2'd1;
  localparam logic [1:0]   M_DOWN = 2'd2;
  localparam logic [1:0]   M_UPDN = 2'd3;
  localparam logic [W-1:0] ZERO   = '0;
  localparam logic [W-1:0] ONE    = W'(1);
  localparam logic [W-1:0] TOP    = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         dn_q, dn_d;
  logic [1:0]   mode_q;
  logic         ovf_q, pend_q;
  logic         ev;
  logic         restart;

  assign restart = !run_i || (mode_i != mode_q);

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    ev    = 1'b0;
    if (restart) begin
      cnt_d = (mode_i == M_DOWN) ? term_i : ZERO;
      dn_d  = 1'b0;
    end else if (tick_i) begin
      unique case (mode_i)
        M_FREE: begin
          cnt_d = cnt_q + ONE;
          ev    = (cnt_q == TOP);
        end
        M_MOD: begin
          if (cnt_q >= term_i) begin
            cnt_d = ZERO;
            ev    = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        M_DOWN: begin
          if (cnt_q != ZERO) begin
            cnt_d = cnt_q - ONE;
            ev    = (cnt_q == ONE);
          end
        end
        M_UPDN: begin
          if (term_i == ZERO) begin
            cnt_d = ZERO;
            dn_d  = 1'b0;
            ev    = 1'b1;
          end else if (cnt_q == ZERO) begin
            cnt_d = ONE;
            dn_d  = 1'b0;
          end else if (dn_q || cnt_q >= term_i) begin
            cnt_d = cnt_q - ONE;
            ev    = (cnt_q == ONE);
            dn_d  = (cnt_q != ONE);
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= ZERO;
      dn_q   <= 1'b0;
      mode_q <= M_FREE;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dn_q   <= dn_d;
      mode_q <= mode_i;
      ovf_q  <= ev | (ovf_q & ~clr_i);
      pend_q <= (ev & ovf_mask_i) | (pend_q & ~clr_i);
    end
  end

  assign count_o    = cnt_q;
  assign ovf_flag_o = ovf_q;
  assign pend_o     = pend_q;
  assign irq_o      = pend_q & ovf_mask_i & irq_en_i;

  AST_STICKY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_flag_o && !clr_i |=> ovf_flag_o); // R7

  AST_PEND_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> ovf_flag_o); // R8

  AST_IDLE_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !tick_i && mode_i == mode_q |=> $stable(count_o)); // R5

  AST_MOD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && mode_i == M_MOD && mode_q == M_MOD && count_o >= term_i
    |=> count_o == ZERO && ovf_flag_o); // R2

  AST_DOWN_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && mode_i == M_DOWN && mode_q == M_DOWN && count_o == ZERO
    |=> count_o == ZERO); // R3

  AST_UPDN_PEAK_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && mode_i == M_UPDN && mode_q == M_UPDN && term_i > ONE
    && count_o == term_i && !ovf_flag_o |=> !ovf_flag_o); // R4

endmodule

// File: tb/test_mode_timer8.sv
module test_mode_timer8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       run_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [7:0] term_i = 8'd0;
  logic       ovf_mask_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       clr_i = 1'b0;
  logic [7:0] count_o;
  logic       ovf_flag_o, pend_o, irq_o;

  int nchk = 0;
  int nfail = 0;

  always #4 clk_i = ~clk_i;

  mode_timer8 i_mode_timer8 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .run_i(run_i),
    .mode_i(mode_i), .term_i(term_i), .ovf_mask_i(ovf_mask_i),
    .irq_en_i(irq_en_i), .clr_i(clr_i), .count_o(count_o),
    .ovf_flag_o(ovf_flag_o), .pend_o(pend_o), .irq_o(irq_o)
  );

  // {mode, term, run tick mask en clr, exp count, exp flag pend irq}
  localparam int NV = 33;
  localparam logic [25:0] VEC [NV] = '{
    {2'd1, 8'd2, 5'b00110, 8'd0, 3'b000},  // R2 entry
    {2'd1, 8'd2, 5'b11110, 8'd1, 3'b000},
    {2'd1, 8'd2, 5'b11110, 8'd2, 3'b000},
    {2'd1, 8'd2, 5'b11110, 8'd0, 3'b111},  // R2 wrap, R9
    {2'd1, 8'd2, 5'b10110, 8'd0, 3'b111},  // R5 no tick
    {2'd1, 8'd2, 5'b11100, 8'd1, 3'b110},  // R9 enable off
    {2'd1, 8'd2, 5'b10111, 8'd1, 3'b000},  // R7 clear
    {2'd1, 8'd2, 5'b11110, 8'd2, 3'b000},
    {2'd1, 8'd2, 5'b11111, 8'd0, 3'b111},  // R7 set beats clear
    {2'd1, 8'd2, 5'b10011, 8'd0, 3'b000},
    {2'd1, 8'd2, 5'b11010, 8'd1, 3'b000},
    {2'd1, 8'd2, 5'b11010, 8'd2, 3'b000},
    {2'd1, 8'd2, 5'b11010, 8'd0, 3'b100},  // R8 masked event
    {2'd1, 8'd2, 5'b10110, 8'd0, 3'b100},  // R8 no late pend
    {2'd1, 8'd2, 5'b10111, 8'd0, 3'b000},
    {2'd3, 8'd2, 5'b11110, 8'd0, 3'b000},  // R6 mode change
    {2'd3, 8'd2, 5'b11110, 8'd1, 3'b000},  // R4
    {2'd3, 8'd2, 5'b11110, 8'd2, 3'b000},
    {2'd3, 8'd2, 5'b11110, 8'd1, 3'b000},  // R4 peak no flag
    {2'd3, 8'd2, 5'b11110, 8'd0, 3'b111},
    {2'd3, 8'd2, 5'b11111, 8'd1, 3'b000},
    {2'd3, 8'd2, 5'b11110, 8'd2, 3'b000},
    {2'd3, 8'd2, 5'b11110, 8'd1, 3'b000},
    {2'd3, 8'd2, 5'b01110, 8'd0, 3'b000},  // R5 run low
    {2'd2, 8'd3, 5'b00110, 8'd3, 3'b000},  // R3 load
    {2'd2, 8'd3, 5'b11110, 8'd2, 3'b000},
    {2'd2, 8'd3, 5'b11110, 8'd1, 3'b000},
    {2'd2, 8'd3, 5'b11110, 8'd0, 3'b111},
    {2'd2, 8'd3, 5'b11111, 8'd0, 3'b000},  // R3 hold
    {2'd2, 8'd3, 5'b11110, 8'd0, 3'b000},
    {2'd2, 8'd3, 5'b01110, 8'd3, 3'b000},
    {2'd0, 8'd3, 5'b10110, 8'd0, 3'b000},  // R1 entry
    {2'd0, 8'd3, 5'b11110, 8'd1, 3'b000}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic drive(input logic [1:0] m, input logic [7:0] t, input logic [4:0] c);
    mode_i = m; term_i = t;
    {run_i, tick_i, ovf_mask_i, irq_en_i, clr_i} = c;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    drive(2'd0, 8'd0, 5'b00000);
    step();
    chk("R11 count", count_o, 0);
    chk("R11 flags", {ovf_flag_o, pend_o, irq_o}, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    @(negedge clk_i);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25:24], VEC[i][23:16], VEC[i][15:11]);
      step();
      chk($sformatf("R2/R3/R4/R7/R8/R9 vec %0d count", i), count_o, VEC[i][10:3]);
      chk($sformatf("R7/R8/R9 vec %0d flags", i), {ovf_flag_o, pend_o, irq_o}, VEC[i][2:0]);
    end

    // R6: change mode while counting
    drive(2'd1, 8'd9, 5'b11110);
    step(); step(); step();
    chk("R6 pre count", count_o, 2);
    drive(2'd2, 8'd5, 5'b11110);
    step();
    chk("R6 reload", count_o, 5);
    step();
    chk("R6 after", count_o, 4);

    // R5: tick without run
    drive(2'd1, 8'd5, 5'b01110);
    for (int k = 0; k < 4; k++) step();
    chk("R5 no run", count_o, 0);

    // R1: free-running full sweep
    do_reset();
    drive(2'd0, 8'd0, 5'b11110);
    for (int k = 0; k < 255; k++) step();
    chk("R1 top", count_o, 255);
    chk("R1 no flag", ovf_flag_o, 0);
    step();
    chk("R1 wrap", count_o, 0);
    chk("R1 flag", ovf_flag_o, 1);

    // R2: larger terminal value
    do_reset();
    drive(2'd1, 8'd200, 5'b11110);
    step();
    for (int k = 0; k < 200; k++) step();
    chk("R2 peak", count_o, 200);
    chk("R2 peak flag", ovf_flag_o, 0);
    step();
    chk("R2 wrap", count_o, 0);
    chk("R2 wrap flag", ovf_flag_o, 1);

    // R10: zero terminal, modulo and up/down
    for (int m = 1; m < 4; m += 2) begin
      do_reset();
      drive(2'(m), 8'd0, 5'b11110);
      step();
      chk("R10 entry flag", ovf_flag_o, 0);
      step();
      chk("R10 count", count_o, 0);
      chk("R10 flag", ovf_flag_o, 1);
      drive(2'(m), 8'd0, 5'b10111);
      step();
      chk("R10 cleared", ovf_flag_o, 0);
      drive(2'(m), 8'd0, 5'b11110);
      step();
      chk("R10 again", {count_o, ovf_flag_o}, 1);
    end

    // R3: countdown with zero terminal never flags
    do_reset();
    drive(2'd2, 8'd0, 5'b11110);
    for (int k = 0; k < 5; k++) step();
    chk("R3 zero term count", count_o, 0);
    chk("R3 zero term flag", ovf_flag_o, 0);

    // R4: terminal 1 triangle flags on every return to zero
    do_reset();
    drive(2'd3, 8'd1, 5'b11110);
    step();
    step();
    chk("R4 t1 up", {count_o, ovf_flag_o}, 2);
    step();
    chk("R4 t1 down", {count_o, ovf_flag_o}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule